// File: doc/BRIEF.md
# Serial Control Register File

This block takes 12-bit control words from a write-only three-wire serial port: a data line, a bit clock and an active-low enable strobe. Each word carries a 2-bit address and 10 data bits. When the strobe closes the frame, the word goes to one of four holding registers. The registers drive the rest of the chip directly as parallel outputs:

- a gain code
- an auxiliary DAC code
- a clamp reference code
- a pulse polarity word

The serial pins are first brought into the system clock domain through synchronizer chains. Serial edges are then found by comparing the synchronized value with the previous one. The system clock must be at least a few times faster than the serial clock (5 MHz serial against 100 MHz system).

An optional sync-gated mode holds a new gain value pending. The pending value reaches the gain output only on the next frame sync pulse, which keeps gain changes aligned with frame boundaries.

Top module: `sctl_regfile`

## Requirements
- R1: After reset, the gain, DAC, clamp and polarity outputs are all zero, and the padding error flag is low. A polarity bit of 0 selects active-high for its pulse.
- R2: A frame is shifted most significant bit first: two address bits, then ten data bits, bit 9 down to bit 0. Address 0 loads the gain output from data bits 8..0.
- R3: Address 1 loads the DAC output from data bits 7..0.
- R4: Address 2 loads the clamp output from data bits 6..0.
- R5: Address 3 loads the polarity output from data bits 5..0. Polarity bit i selects the active level of pulse i (0 = active high, 1 = active low).
- R6: A frame is committed on the rising edge of the enable only when exactly 12 serial clock rising edges were counted. A frame of 11 or 13 bits changes no output.
- R7: Serial clock edges that arrive while the enable is high are not counted and shift nothing. A correct frame that follows them still commits.
- R8: A committed frame whose unused high data bits are not all zero still loads its register. It also sets a sticky error flag, which stays high until reset.
- R9: With the sync gate input high, a gain frame leaves the gain output unchanged. The new value appears after the next frame sync pulse. Frames to the other three addresses update their outputs immediately in this mode.
- R10: With the sync gate input low, a gain frame updates the gain output directly.
- R11: A committed frame changes only the register it addresses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| serClk | input | 1 | Serial bit clock; data is sampled on its rising edge |
| serData | input | 1 | Serial data, MSB first |
| serEnN | input | 1 | Active-low frame enable; the rising edge commits the frame |
| syncGateEn | input | 1 | Holds gain writes pending until frame sync |
| frameSync | input | 1 | Frame sync pulse, synchronous to clk |
| gainCode | output | 9 | Gain register |
| dacCode | output | 8 | Auxiliary DAC register |
| clampCode | output | 7 | Clamp reference register |
| polarity | output | 6 | Pulse polarity selects |
| padErr | output | 1 | Sticky flag for non-zero padding |

## Verification
Each address is written with asymmetric data patterns. A bit-order or field-slice error therefore shows up as a wrong value, and the untouched registers are compared at the same time to catch cross-writes. Frames of 11 and 13 bits tell an exact-count commit apart from a "twelve or more" commit. Stray serial clocks sent while the enable is high then separate gated counting from free counting. Sync-gated gain writes are checked both before and after the sync pulse, with a DAC write in between, to show that only the gain waits.

// File: rtl/sctl_pkg.sv
package sctl_pkg;
  localparam int ADDR_W    = 2;
  localparam int DATA_W    = 10;
  localparam int FRAME_W   = ADDR_W + DATA_W;
  localparam int GAIN_W    = 9;
  localparam int DAC_W     = 8;
  localparam int CLAMP_W   = 7;
  localparam int POL_W     = 6;

  typedef enum logic [ADDR_W-1:0] {
    ADDR_GAIN  = 2'd0,
    ADDR_DAC   = 2'd1,
    ADDR_CLAMP = 2'd2,
    ADDR_POL   = 2'd3
  } regSel_e;

  typedef struct packed {
    logic shiftEn;
    logic shiftBit;
    logic commit;
  } ctlStrobe_t;

  // Bits above a register's width must be zero.
  function automatic logic [DATA_W-1:0] padMask(input regSel_e sel);
    logic [DATA_W-1:0] full;
    full = '1;
    case (sel)
      ADDR_GAIN:  padMask = full << GAIN_W;
      ADDR_DAC:   padMask = full << DAC_W;
      ADDR_CLAMP: padMask = full << CLAMP_W;
      default:    padMask = full << POL_W;
    endcase
  endfunction
endpackage

// File: rtl/sctl_sync.sv
module sctl_sync #(
  parameter int WIDTH  = 3,
  parameter int STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stageQ [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) stageQ[s] <= RST_VAL;
      else if (s == 0) stageQ[s] <= asyncIn;
      else stageQ[s] <= stageQ[(s == 0) ? 0 : s-1];
    end
  end

  assign syncOut = stageQ[STAGES-1];
endmodule

// File: rtl/sctl_frame_ctrl.sv
module sctl_frame_ctrl
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       serClk,
  input  logic       serData,
  input  logic       serEnN,
  output ctlStrobe_t strb
);
  localparam int CNT_MAX = FRAME_W + 1;
  localparam int CNT_W   = $clog2(CNT_MAX + 1);

  logic [2:0] syncVec;
  logic       sClk, sData, sEnN;
  logic       prevClk, prevEnN;
  logic [CNT_W-1:0] bitCnt;
  logic       clkRise, enRise;

  sctl_sync #(
    .WIDTH(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b100)
  ) u_sync (
    .clk(clk), .rstN(rstN),
    .asyncIn({serEnN, serData, serClk}),
    .syncOut(syncVec)
  );

  assign sClk  = syncVec[0];
  assign sData = syncVec[1];
  assign sEnN  = syncVec[2];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      prevEnN <= 1'b1;
    end else begin
      prevClk <= sClk;
      prevEnN <= sEnN;
    end
  end

  assign clkRise = sClk & ~prevClk;
  assign enRise  = sEnN & ~prevEnN;

  always_comb begin
    strb.shiftEn  = clkRise & ~sEnN;
    strb.shiftBit = sData;
    strb.commit   = enRise && (bitCnt == CNT_W'(FRAME_W));
  end

  // Count saturates one above a full frame so overlong frames are rejected.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) bitCnt <= '0;
    else if (enRise) bitCnt <= '0;
    else if (strb.shiftEn && bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
  end

  p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rstN)
    bitCnt <= CNT_W'(CNT_MAX));
  p_cnt_clear_r6: assert property (@(posedge clk) disable iff (!rstN)
    strb.commit |=> bitCnt == '0);
  p_idle_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (sEnN && !enRise) |=> $stable(bitCnt));
endmodule

// File: rtl/sctl_regs_dp.sv
module sctl_regs_dp
  import sctl_pkg::*;
(
  input  logic               clk,
  input  logic               rstN,
  input  ctlStrobe_t         strb,
  input  logic               syncGateEn,
  input  logic               frameSync,
  output logic [GAIN_W-1:0]  gainCode,
  output logic [DAC_W-1:0]   dacCode,
  output logic [CLAMP_W-1:0] clampCode,
  output logic [POL_W-1:0]   polarity,
  output logic               padErr
);
  logic [FRAME_W-1:0] shiftQ;
  regSel_e            sel;
  logic [DATA_W-1:0]  payload;
  logic [GAIN_W-1:0]  pendGain;
  logic               pendValid;
  logic               gainWrite;

  assign sel       = regSel_e'(shiftQ[FRAME_W-1 -: ADDR_W]);
  assign payload   = shiftQ[DATA_W-1:0];
  assign gainWrite = strb.commit && (sel == ADDR_GAIN);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) shiftQ <= '0;
    else if (strb.shiftEn) shiftQ <= {shiftQ[FRAME_W-2:0], strb.shiftBit};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dacCode   <= '0;
      clampCode <= '0;
      polarity  <= '0;
    end else if (strb.commit) begin
      case (sel)
        ADDR_DAC:   dacCode   <= payload[DAC_W-1:0];
        ADDR_CLAMP: clampCode <= payload[CLAMP_W-1:0];
        ADDR_POL:   polarity  <= payload[POL_W-1:0];
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      gainCode  <= '0;
      pendGain  <= '0;
      pendValid <= 1'b0;
    end else if (gainWrite) begin
      if (syncGateEn) begin
        pendGain  <= payload[GAIN_W-1:0];
        pendValid <= 1'b1;
      end else begin
        gainCode  <= payload[GAIN_W-1:0];
        pendValid <= 1'b0;
      end
    end else if (frameSync && pendValid) begin
      gainCode  <= pendGain;
      pendValid <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) padErr <= 1'b0;
    else if (strb.commit && |(payload & padMask(sel))) padErr <= 1'b1;
  end

  p_err_sticky_r8: assert property (@(posedge clk) disable iff (!rstN)
    padErr |=> padErr);
  p_dac_hold_r3: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(dacCode));
  p_pol_hold_r5: assert property (@(posedge clk) disable iff (!rstN)
    !strb.commit |=> $stable(polarity) && $stable(clampCode));
  p_gain_gated_r9: assert property (@(posedge clk) disable iff (!rstN)
    (syncGateEn && !frameSync) |=> $stable(gainCode));
  p_gain_direct_r10: assert property (@(posedge clk) disable iff (!rstN)
    (gainWrite && !syncGateEn) |=> gainCode == $past(payload[GAIN_W-1:0]));
endmodule

// File: rtl/sctl_regfile.sv
module sctl_regfile
  import sctl_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               serClk,
  input  logic               serData,
  input  logic               serEnN,
  input  logic               syncGateEn,
  input  logic               frameSync,
  output logic [GAIN_W-1:0]  gainCode,
  output logic [DAC_W-1:0]   dacCode,
  output logic [CLAMP_W-1:0] clampCode,
  output logic [POL_W-1:0]   polarity,
  output logic               padErr
);
  ctlStrobe_t strb;

  sctl_frame_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN),
    .serClk(serClk), .serData(serData), .serEnN(serEnN),
    .strb(strb)
  );

  sctl_regs_dp u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .syncGateEn(syncGateEn), .frameSync(frameSync),
    .gainCode(gainCode), .dacCode(dacCode), .clampCode(clampCode),
    .polarity(polarity), .padErr(padErr)
  );
endmodule

// File: tb/tb_sctl_regfile.sv
module tb_sctl_regfile;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic serClk = 1'b0, serData = 1'b0, serEnN = 1'b1;
  logic syncGateEn = 1'b0, frameSync = 1'b0;
  logic [8:0] gainCode;
  logic [7:0] dacCode;
  logic [6:0] clampCode;
  logic [5:0] polarity;
  logic padErr;

  always #5 clk = ~clk;

  sctl_regfile dut (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serEnN(serEnN), .syncGateEn(syncGateEn), .frameSync(frameSync),
    .gainCode(gainCode), .dacCode(dacCode), .clampCode(clampCode),
    .polarity(polarity), .padErr(padErr)
  );

  typedef struct packed {
    logic [8:0] g; logic [7:0] d; logic [6:0] c; logic [5:0] p; logic e;
  } snap_t;

  snap_t expQ[$];
  string tagQ[$];
  int nChecks = 0, nFail = 0;
  bit finished = 1'b0;
  snap_t model = '0;

  task automatic checkField(string tag, string name, int act, int exp);
    nChecks++;
    if (act != exp) begin
      nFail++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, name, act, exp);
    end
  endtask

  // Monitor: pops expectations once outputs have settled.
  initial begin
    forever begin
      wait (expQ.size() != 0);
      repeat (8) @(negedge clk);
      begin
        snap_t e;
        string t;
        e = expQ.pop_front();
        t = tagQ.pop_front();
        checkField(t, "gain",  int'(gainCode),  int'(e.g));
        checkField(t, "dac",   int'(dacCode),   int'(e.d));
        checkField(t, "clamp", int'(clampCode), int'(e.c));
        checkField(t, "pol",   int'(polarity),  int'(e.p));
        checkField(t, "err",   int'(padErr),    int'(e.e));
      end
    end
  end

  task automatic expect_(string tag);
    expQ.push_back(model);
    tagQ.push_back(tag);
    wait (expQ.size() == 0);
    repeat (2) @(negedge clk);
  endtask

  task automatic serHalf();
    repeat (10) @(negedge clk);
  endtask

  task automatic sendBits(input logic [15:0] bits, input int n);
    serEnN = 1'b0;
    serHalf();
    for (int i = n - 1; i >= 0; i--) begin
      serData = bits[i];
      serHalf();
      serClk = 1'b1;
      serHalf();
      serClk = 1'b0;
    end
    serHalf();
    serEnN = 1'b1;
    serHalf();
  endtask

  function automatic logic [15:0] frame(input logic [1:0] a, input logic [9:0] d);
    return {4'b0, a, d};
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++; nFail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;
    repeat (4) @(negedge clk);
    expect_("R1 reset");

    sendBits(frame(2'd0, 10'h15A), 12); model.g = 9'h15A;
    expect_("R2 gain load");
    sendBits(frame(2'd0, 10'h0A7), 12); model.g = 9'h0A7;
    expect_("R10 direct gain");

    sendBits(frame(2'd1, 10'h0C3), 12); model.d = 8'hC3;
    expect_("R3 dac load R11");
    sendBits(frame(2'd2, 10'h05A), 12); model.c = 7'h5A;
    expect_("R4 clamp load R11");
    sendBits(frame(2'd3, 10'h02D), 12); model.p = 6'h2D;
    expect_("R5 polarity load R11");

    sendBits(frame(2'd1, 10'h011) >> 1, 11);
    expect_("R6 short frame");
    sendBits({frame(2'd1, 10'h022), 1'b1}, 13);
    expect_("R6 long frame");

    // Stray clocks while enable is high, then a good frame.
    for (int k = 0; k < 3; k++) begin
      serData = 1'b1; serHalf(); serClk = 1'b1; serHalf(); serClk = 1'b0;
    end
    expect_("R7 idle clocks");
    sendBits(frame(2'd2, 10'h033), 12); model.c = 7'h33;
    expect_("R7 frame after idle clocks");

    syncGateEn = 1'b1;
    sendBits(frame(2'd0, 10'h1E1), 12);
    expect_("R9 gain pending");
    sendBits(frame(2'd1, 10'h05E), 12); model.d = 8'h5E;
    expect_("R9 dac immediate");
    @(negedge clk); frameSync = 1'b1; @(negedge clk); frameSync = 1'b0;
    model.g = 9'h1E1;
    expect_("R9 gain applied at sync");
    syncGateEn = 1'b0;

    sendBits(frame(2'd3, 10'h3D5), 12); model.p = 6'h15; model.e = 1'b1;
    expect_("R8 padding error");
    sendBits(frame(2'd1, 10'h099), 12); model.d = 8'h99;
    expect_("R8 sticky");

    finished = 1'b1;
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end
endmodule